// File: doc/BRIEF.md
# Supervisor and Guest Timer Comparator

This block watches a free-running time value supplied by an external counter and raises two level-sensitive timer-pending outputs. The first output belongs to the supervisor and compares the raw time against a supervisor compare register. The second output belongs to a virtualized guest. It compares a guest compare register against the time plus a programmable guest offset.

Software programs the two compare registers and the offset through a small register port. It clears a pending line by writing a compare value larger than the relevant time. It leaves a line pending by writing a value at or below that time. Both outputs are registered. Each reflects a compare or offset write on the clock edge after the write is accepted.

Top module: `dual_timecmp`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), all three registers clear to zero, both pending outputs are low, and register writes are ignored. On the first edge after release with time 0, both outputs go high, because 0 >= 0.
- R2: On every clock edge out of reset, `s_pend` registers the result of (`time_i` >= supervisor compare) as unsigned values. It uses the compare value held before that edge, so a write is visible one edge later.
- R3: On every clock edge out of reset, `g_pend` registers the result of (`time_i` + guest offset) >= guest compare. The same one-edge latency applies to compare and offset writes.
- R4: The guest time sum wraps modulo 2^TW with no saturation, so an offset that carries past the top yields a small effective time.
- R5: Pending is a level. It stays high for as long as the condition holds, with no further write. It drops one edge after a compare larger than the time is written, and it rises one edge after a compare at or below the time is written.
- R6: With a compare of all ones, pending is high only for the edge where the compared time equals all ones. It is low again once the time wraps to zero.
- R7: The two outputs are independent. A write to the supervisor compare changes neither the guest compare, the offset nor `g_pend`, and a write to the guest compare does not change `s_pend`.
- R8: `reg_sel` chooses the register: 0 is the supervisor compare, 1 the guest compare, 2 the guest offset. `reg_rdata` returns the selected register combinationally. Select 3 reads zero, and writes to it are ignored.
- R9: Comparisons are unsigned, so a time with its top bit set is greater than any compare with its top bit clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_i | input | TW | Free-running time value |
| reg_wen | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 sup compare, 1 guest compare, 2 guest offset) |
| reg_wdata | input | TW | Write data |
| reg_rdata | output | TW | Read data for the selected register |
| s_pend | output | 1 | Supervisor timer pending |
| g_pend | output | 1 | Guest timer pending |

## Verification
The bench runs the comparator at an 8-bit time width and sweeps every time value against a set of compare and offset pairs. The pairs include zero, one, the sign boundary and all ones.

A signed comparison would fail the top-half sweep. A saturating offset adder would leave the guest line stuck high once the sum crosses the top. A compare that latched pending as a sticky edge, instead of a level, would hold the line high after time wrapped past an all-ones compare.

Crossed writes between the two compare registers, a live select 3, and writes leaking through reset are checked by reading the registers back and watching the other output.

// File: rtl/dual_timecmp_pkg.sv
package dual_timecmp_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_SCMP = 2'd0,
        SEL_GCMP = 2'd1,
        SEL_GOFS = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/dual_timecmp_regs.sv
module dual_timecmp_regs
    import dual_timecmp_pkg::*;
#(
    parameter int TW = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wen,
    input  logic [SEL_W-1:0] sel,
    input  logic [TW-1:0]    wdata,
    output logic [TW-1:0]    rdata,
    output logic [TW-1:0]    scmp_o,
    output logic [TW-1:0]    gcmp_o,
    output logic [TW-1:0]    gofs_o
);
    typedef struct packed {
        logic [TW-1:0] scmp;
        logic [TW-1:0] gcmp;
        logic [TW-1:0] gofs;
    } regs_t;

    regs_t regs_d, regs_q;
    reg_sel_e sel_e;

    assign sel_e = reg_sel_e'(sel);

    always_comb begin
        regs_d = regs_q;
        if (wen) begin
            unique case (sel_e)
                SEL_SCMP: regs_d.scmp = wdata;
                SEL_GCMP: regs_d.gcmp = wdata;
                SEL_GOFS: regs_d.gofs = wdata;
                default:  regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        unique case (sel_e)
            SEL_SCMP: rdata = regs_q.scmp;
            SEL_GCMP: rdata = regs_q.gcmp;
            SEL_GOFS: rdata = regs_q.gofs;
            default:  rdata = '0;
        endcase
    end

    assign scmp_o = regs_q.scmp;
    assign gcmp_o = regs_q.gcmp;
    assign gofs_o = regs_q.gofs;
endmodule

// File: rtl/dual_timecmp_cmp.sv
module dual_timecmp_cmp #(
    parameter int TW      = 64,
    parameter bit HAS_OFS = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] time_i,
    input  logic [TW-1:0] ofs_i,
    input  logic [TW-1:0] cmp_i,
    output logic          pend_o
);
    logic [TW-1:0] eff_time;
    logic          pend_d, pend_q;

    generate
        if (HAS_OFS) begin : g_ofs
            // modulo 2^TW sum, carry out dropped on purpose
            assign eff_time = time_i + ofs_i;
        end else begin : g_raw
            logic unused_ofs;
            assign unused_ofs = ^ofs_i;
            assign eff_time   = time_i;
        end
    endgenerate

    always_comb begin
        pend_d = (eff_time >= cmp_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/dual_timecmp.sv
module dual_timecmp
    import dual_timecmp_pkg::*;
#(
    parameter int TW = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TW-1:0]    time_i,
    input  logic             reg_wen,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [TW-1:0]    reg_wdata,
    output logic [TW-1:0]    reg_rdata,
    output logic             s_pend,
    output logic             g_pend
);
    logic [TW-1:0] scmp_w, gcmp_w, gofs_w;

    dual_timecmp_regs #(.TW(TW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wen    (reg_wen),
        .sel    (reg_sel),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .scmp_o (scmp_w),
        .gcmp_o (gcmp_w),
        .gofs_o (gofs_w)
    );

    dual_timecmp_cmp #(.TW(TW), .HAS_OFS(1'b0)) u_sup (
        .clk    (clk),
        .rst_n  (rst_n),
        .time_i (time_i),
        .ofs_i  ('0),
        .cmp_i  (scmp_w),
        .pend_o (s_pend)
    );

    dual_timecmp_cmp #(.TW(TW), .HAS_OFS(1'b1)) u_gst (
        .clk    (clk),
        .rst_n  (rst_n),
        .time_i (time_i),
        .ofs_i  (gofs_w),
        .cmp_i  (gcmp_w),
        .pend_o (g_pend)
    );
endmodule

// File: rtl/dual_timecmp_chk.sv
module dual_timecmp_chk #(
    parameter int TW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic [TW-1:0] time_i,
    input logic          reg_wen,
    input logic [1:0]    reg_sel,
    input logic [TW-1:0] scmp,
    input logic [TW-1:0] gcmp,
    input logic [TW-1:0] gofs,
    input logic          s_pend,
    input logic          g_pend
);
    logic [TW-1:0] model_gtime;
    assign model_gtime = time_i + gofs;

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (scmp == '0 && gcmp == '0 && gofs == '0 && !s_pend && !g_pend));

    assert_sup_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (s_pend == ($past(time_i) >= $past(scmp))));

    assert_guest_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (g_pend == ($past(model_gtime) >= $past(gcmp))));

    assert_allones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(scmp) == '1) |-> (s_pend == ($past(time_i) == '1)));

    assert_separate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_sel == 2'd0) |=> ($stable(gcmp) && $stable(gofs)));

    assert_dead_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_sel == 2'd3) |=> ($stable(scmp) && $stable(gcmp) && $stable(gofs)));
endmodule

bind dual_timecmp dual_timecmp_chk #(.TW(TW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .time_i  (time_i),
    .reg_wen (reg_wen),
    .reg_sel (reg_sel),
    .scmp    (scmp_w),
    .gcmp    (gcmp_w),
    .gofs    (gofs_w),
    .s_pend  (s_pend),
    .g_pend  (g_pend)
);

// File: tb/dual_timecmp_test.sv
module dual_timecmp_test;
    localparam int TW = 8;
    localparam int N  = 1 << TW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [TW-1:0] time_i;
    logic          reg_wen;
    logic [1:0]    reg_sel;
    logic [TW-1:0] reg_wdata;
    logic [TW-1:0] reg_rdata;
    logic          s_pend, g_pend;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    dual_timecmp #(.TW(TW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .time_i    (time_i),
        .reg_wen   (reg_wen),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .s_pend    (s_pend),
        .g_pend    (g_pend)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int sel, input int data);
        reg_sel   = sel[1:0];
        reg_wdata = data[TW-1:0];
        reg_wen   = 1'b1;
        tick();
        reg_wen   = 1'b0;
    endtask

    task automatic rd(input int sel, input int exp, input string req);
        reg_sel = sel[1:0];
        #1;
        check(req, int'(reg_rdata), exp);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int ofs_l[5];
        int cmp_l[5];
        ofs_l = '{0, 1, 'h37, 'h80, 'hFF};
        cmp_l = '{0, 'h10, 'h7F, 'h80, 'hFE};

        rst_n = 1'b0; reg_wen = 1'b0; reg_sel = 2'd0; reg_wdata = '0; time_i = 8'h33;
        repeat (3) tick();
        // R1: reset state, and a write during reset is ignored
        wr(0, 'h55);
        check("R1 s_pend in reset", int'(s_pend), 0);
        check("R1 g_pend in reset", int'(g_pend), 0);
        rd(0, 0, "R1 scmp reset");
        rd(1, 0, "R1 gcmp reset");
        rd(2, 0, "R1 gofs reset");
        rst_n = 1'b1; time_i = '0;
        tick();
        check("R1 s_pend zero cmp", int'(s_pend), 1);
        check("R1 g_pend zero cmp", int'(g_pend), 1);

        // R8: register map and dead select
        wr(0, 'hA1); wr(1, 'hB2); wr(2, 'hC3);
        rd(0, 'hA1, "R8 sel0");
        rd(1, 'hB2, "R8 sel1");
        rd(2, 'hC3, "R8 sel2");
        wr(3, 'h5A);
        rd(3, 0, "R8 sel3 reads zero");
        rd(0, 'hA1, "R8 sel3 write ignored s");
        rd(1, 'hB2, "R8 sel3 write ignored g");
        rd(2, 'hC3, "R8 sel3 write ignored o");

        // R2 R3 R4 R9: full time sweep over compare/offset pairs
        foreach (ofs_l[i]) begin
            foreach (cmp_l[j]) begin
                int sc;
                sc = (cmp_l[j] + ofs_l[i] * 3) % N;
                wr(0, sc); wr(1, cmp_l[j]); wr(2, ofs_l[i]);
                tick();
                for (int t = 0; t < N; t++) begin
                    int eff;
                    time_i = t[TW-1:0];
                    tick();
                    eff = (t + ofs_l[i]) % N;
                    check((t >= N/2) ? "R2 R9 sup unsigned" : "R2 sup compare",
                          int'(s_pend), (t >= sc) ? 1 : 0);
                    check((t + ofs_l[i] >= N) ? "R3 R4 guest wrap" : "R3 guest compare",
                          int'(g_pend), (eff >= cmp_l[j]) ? 1 : 0);
                end
            end
        end

        // R7: independence of the two compares
        wr(2, 0);
        time_i = 8'h40;
        wr(0, 'h30); wr(1, 'h90); tick();
        check("R7 base s", int'(s_pend), 1);
        check("R7 base g", int'(g_pend), 0);
        wr(1, 'h10); tick();
        check("R7 g follows gcmp", int'(g_pend), 1);
        check("R7 s untouched by gcmp", int'(s_pend), 1);
        wr(0, 'hF0); tick();
        check("R7 s follows scmp", int'(s_pend), 0);
        check("R7 g untouched by scmp", int'(g_pend), 1);
        rd(1, 'h10, "R7 gcmp kept");

        // R5: level holds, clears on larger write, sets on equal write
        time_i = 8'h50;
        wr(0, 'h20); tick();
        for (int k = 0; k < 4; k++) begin
            tick();
            check("R5 level held", int'(s_pend), 1);
        end
        wr(0, 'h60); tick();
        check("R5 cleared by larger cmp", int'(s_pend), 0);
        wr(0, 'h50); tick();
        check("R5 set by equal cmp", int'(s_pend), 1);

        // R6: all-ones compare, supervisor and guest
        wr(0, 'hFF); wr(1, 'hFF); wr(2, 1);
        time_i = 8'hFD; tick();
        time_i = 8'hFE; tick();
        check("R6 sup below", int'(s_pend), 0);
        check("R6 guest at max", int'(g_pend), 1);
        time_i = 8'hFF; tick();
        check("R6 sup at max", int'(s_pend), 1);
        check("R6 guest wrapped", int'(g_pend), 0);
        time_i = 8'h00; tick();
        check("R6 sup wrapped", int'(s_pend), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule